// File: doc/BRIEF.md
# Polynomial Support-Vector Classifier Chain

This block decides whether a feature vector belongs to the positive class ("face") or not, using a trained support-vector model with a second-degree polynomial kernel. The vector enters one unsigned element per accepted clock. It flows along a linear chain of processing elements. Each element keeps one support vector in its own small memory. As the stream passes, each element multiplies the element it currently sees by the matching support-vector entry and adds the product to its accumulator. Every element forwards the feature one cycle later, so the dot products finish in chain order, one cycle apart.

A single aggregation stage sits at the tail of the chain. It takes each finished dot product in turn and squares the dot product plus one. It scales the result by that support vector's coefficient and adds it to a running sum. When the last element of the chain reports, the aggregator adds the bias and raises a one-cycle result strobe with the decision bit. Model values (support-vector entries, coefficients and the bias) are written through a small configuration port while no vector is in flight.

Top module: `svm_poly_chain`

## Requirements
- R1: After reset, `result_valid` is low and stays low until a complete feature vector has been streamed in.
- R2: For chain element k, the dot product is the sum over i of feature element i (unsigned, `FEAT_W` bits) times support-vector entry i of element k (signed, `COEF_W` bits). Element i is the i-th accepted element counted from the one that arrived with `start`.
- R3: `result_face` is 1 exactly when the sum over all k of alpha_k * (dot_k + 1)^2, plus the bias, is strictly greater than zero. A sum of exactly zero gives 0.
- R4: A configuration write with `cfg_we` high uses `cfg_kind` as follows. `cfg_kind`=0 stores `cfg_data` as entry `cfg_addr` of element `cfg_pe`'s support vector. `cfg_kind`=1 stores it as element `cfg_pe`'s coefficient alpha. `cfg_kind`=2 stores it as the bias. `cfg_kind`=3 changes nothing.
- R5: A vector opens on a cycle with both `start` and `feat_valid` high. `start` then discards any partial vector, which produces no result. An element with `feat_valid` high outside an open vector and without `start` is ignored.
- R6: Cycles with `feat_valid` low inside a vector hold the stream and do not change the result.
- R7: `result_valid` is high for exactly one cycle, `NUM_SV`+1 cycles after the cycle in which the last element (the `FEAT_LEN`-th) is presented. Chain element k finishes its dot product one cycle after element k-1.
- R8: Vectors may follow each other with no idle cycle in between. Each complete vector yields exactly one result, in arrival order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Marks the first element of a vector (with `feat_valid`) |
| feat_valid | input | 1 | Feature element present this cycle |
| feat_data | input | FEAT_W | Unsigned feature element |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_kind | input | 2 | 0 support-vector entry, 1 alpha, 2 bias, 3 none |
| cfg_pe | input | PE_AW | Chain element selected by the write |
| cfg_addr | input | AW | Support-vector entry index |
| cfg_data | input | COEF_W | Signed value written |
| result_valid | output | 1 | One-cycle strobe with a decision |
| result_face | output | 1 | Decision: 1 when the kernel sum is positive |

## Verification
The decision boundary is the hardest case to reach from the ports. With random models the weighted sum is almost never near zero, so a wrong comparison or a missing "+1" in the kernel would go unnoticed. The bench therefore loads hand-built models. In one, an all-zero feature vector makes every kernel exactly 1, and the bias is set so that the total is exactly zero and then exactly one. In the other, each support vector holds -1 in entry 0 and a single feature of 1 drives every dot product to -1, which forces every kernel to zero. Partial vectors cut off by a new `start`, and stray elements with no open vector, are interleaved with complete vectors. This shows that only complete vectors produce results.

// File: rtl/svm_pkg.sv
package svm_pkg;
   typedef enum logic [1:0] {
      CFG_SV    = 2'd0,
      CFG_ALPHA = 2'd1,
      CFG_BIAS  = 2'd2,
      CFG_NONE  = 2'd3
   } cfg_kind_e;
endpackage

// File: rtl/svm_feed.sv
module svm_feed #(
   parameter int FEAT_W   = 8,
   parameter int FEAT_LEN = 64,
   localparam int AW      = $clog2(FEAT_LEN)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              feat_valid,
   input  logic [FEAT_W-1:0] feat_data,
   output logic              s_valid,
   output logic              s_start,
   output logic              s_last,
   output logic [AW-1:0]     s_addr,
   output logic [FEAT_W-1:0] s_data
);
   logic [AW-1:0] cnt_q;
   logic          open_q;

   always_comb begin
      s_valid = feat_valid && (start || open_q);
      s_start = start;
      s_addr  = start ? '0 : cnt_q;
      s_last  = (s_addr == AW'(FEAT_LEN - 1));
      s_data  = feat_data;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         open_q <= 1'b0;
      end else if (s_valid) begin
         cnt_q  <= s_last ? '0 : s_addr + AW'(1);
         open_q <= !s_last;
      end
   end

   AST_CLOSE_ON_LAST: assert property (@(posedge clk) disable iff (!rst_n)
      (s_valid && s_last) |=> !open_q);  // R5
   AST_OPEN_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
      (feat_valid && start && !s_last) |=> open_q);  // R5
endmodule

// File: rtl/svm_pe.sv
module svm_pe #(
   parameter int FEAT_W   = 8,
   parameter int COEF_W   = 16,
   parameter int ACC_W    = 48,
   parameter int FEAT_LEN = 64,
   localparam int AW      = $clog2(FEAT_LEN),
   localparam int PW      = FEAT_W + 1 + COEF_W
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     in_valid,
   input  logic                     in_start,
   input  logic                     in_last,
   input  logic [AW-1:0]            in_addr,
   input  logic [FEAT_W-1:0]        in_data,
   input  logic                     wr_en,
   input  logic [AW-1:0]            wr_addr,
   input  logic signed [COEF_W-1:0] wr_data,
   output logic                     out_valid,
   output logic                     out_start,
   output logic                     out_last,
   output logic [AW-1:0]            out_addr,
   output logic [FEAT_W-1:0]        out_data,
   output logic signed [ACC_W-1:0]  dot,
   output logic                     done
);
   logic signed [COEF_W-1:0] sv_mem [FEAT_LEN];
   logic signed [PW-1:0]     f_x, c_x, prod;
   logic signed [ACC_W-1:0]  prod_x;

   always_ff @(posedge clk) begin
      if (wr_en) sv_mem[wr_addr] <= wr_data;
   end

   always_comb begin
      f_x    = PW'($signed({1'b0, in_data}));
      c_x    = PW'(sv_mem[in_addr]);
      prod   = f_x * c_x;
      prod_x = ACC_W'(prod);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_start <= 1'b0;
         out_last  <= 1'b0;
         out_addr  <= '0;
         out_data  <= '0;
         dot       <= '0;
         done      <= 1'b0;
      end else begin
         out_valid <= in_valid;
         out_start <= in_start;
         out_last  <= in_last;
         out_addr  <= in_addr;
         out_data  <= in_data;
         done      <= in_valid && in_last;
         if (in_valid) dot <= in_start ? prod_x : dot + prod_x;
      end
   end

   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);  // R7
   AST_DOT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(in_valid) |-> $stable(dot));  // R6
endmodule

// File: rtl/svm_aggr.sv
module svm_aggr #(
   parameter int NUM_SV   = 8,
   parameter int COEF_W   = 16,
   parameter int ACC_W    = 48,
   localparam int PE_AW   = (NUM_SV > 1) ? $clog2(NUM_SV) : 1,
   localparam int KW      = 2 * (ACC_W + 1),
   localparam int TW      = KW + COEF_W,
   localparam int SW      = TW + $clog2(NUM_SV + 1) + 1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [NUM_SV-1:0]        done,
   input  logic [NUM_SV*ACC_W-1:0]  dots,
   input  logic                     wr_alpha,
   input  logic                     wr_bias,
   input  logic [PE_AW-1:0]         wr_idx,
   input  logic signed [COEF_W-1:0] wr_data,
   output logic                     result_valid,
   output logic                     result_face
);
   logic signed [COEF_W-1:0] alpha_q [NUM_SV];
   logic signed [COEF_W-1:0] bias_q;
   logic signed [ACC_W-1:0]  sel_dot;
   logic signed [COEF_W-1:0] sel_alpha;
   logic signed [ACC_W:0]    kval;
   logic signed [KW-1:0]     kval_x, ksq;
   logic signed [TW-1:0]     term;
   logic signed [SW-1:0]     sum_q, base, nxt, total;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int k = 0; k < NUM_SV; k++) alpha_q[k] <= '0;
         bias_q <= '0;
      end else begin
         if (wr_alpha && (int'(wr_idx) < NUM_SV)) alpha_q[wr_idx] <= wr_data;
         if (wr_bias) bias_q <= wr_data;
      end
   end

   always_comb begin
      sel_dot   = '0;
      sel_alpha = '0;
      for (int k = 0; k < NUM_SV; k++) begin
         if (done[k]) begin
            sel_dot   = dots[k*ACC_W +: ACC_W];
            sel_alpha = alpha_q[k];
         end
      end
      kval   = (ACC_W + 1)'(sel_dot) + (ACC_W + 1)'(1);
      kval_x = KW'(kval);
      ksq    = kval_x * kval_x;
      term   = TW'(ksq) * TW'(sel_alpha);
      base   = done[0] ? '0 : sum_q;
      nxt    = base + SW'(term);
      total  = nxt + SW'(bias_q);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sum_q        <= '0;
         result_valid <= 1'b0;
         result_face  <= 1'b0;
      end else begin
         if (|done) sum_q <= nxt;
         result_valid <= done[NUM_SV-1];
         if (done[NUM_SV-1]) result_face <= !total[SW-1] && (total != '0);
      end
   end

   AST_RESULT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      result_valid |=> !result_valid);  // R7
   AST_FACE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(done[NUM_SV-1]) |-> $stable(result_face));  // R8
endmodule

// File: rtl/svm_poly_chain.sv
module svm_poly_chain #(
   parameter int NUM_SV   = 8,
   parameter int FEAT_LEN = 64,
   parameter int FEAT_W   = 8,
   parameter int COEF_W   = 16,
   parameter int ACC_W    = 48,
   localparam int AW      = $clog2(FEAT_LEN),
   localparam int PE_AW   = (NUM_SV > 1) ? $clog2(NUM_SV) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              feat_valid,
   input  logic [FEAT_W-1:0] feat_data,
   input  logic              cfg_we,
   input  logic [1:0]        cfg_kind,
   input  logic [PE_AW-1:0]  cfg_pe,
   input  logic [AW-1:0]     cfg_addr,
   input  logic [COEF_W-1:0] cfg_data,
   output logic              result_valid,
   output logic              result_face
);
   import svm_pkg::*;

   initial begin
      AST_PARAM_CHAIN: assert (FEAT_LEN >= NUM_SV && FEAT_LEN >= 2 && NUM_SV >= 1)
         else $error("feature length must cover the chain length");  // R7
      AST_PARAM_ACC: assert (ACC_W >= FEAT_W + COEF_W + 1 + AW)
         else $error("accumulator too narrow for the dot product");  // R2
   end

   cfg_kind_e kind;
   assign kind = cfg_kind_e'(cfg_kind);

   logic              ch_v [NUM_SV+1];
   logic              ch_s [NUM_SV+1];
   logic              ch_l [NUM_SV+1];
   logic [AW-1:0]     ch_a [NUM_SV+1];
   logic [FEAT_W-1:0] ch_d [NUM_SV+1];
   logic [NUM_SV-1:0]       pe_done;
   logic [NUM_SV*ACC_W-1:0] pe_dots;

   svm_feed #(.FEAT_W(FEAT_W), .FEAT_LEN(FEAT_LEN)) u_feed (
      .clk(clk), .rst_n(rst_n), .start(start), .feat_valid(feat_valid),
      .feat_data(feat_data), .s_valid(ch_v[0]), .s_start(ch_s[0]),
      .s_last(ch_l[0]), .s_addr(ch_a[0]), .s_data(ch_d[0]));

   for (genvar k = 0; k < NUM_SV; k++) begin : g_pe
      logic                    sv_we;
      logic signed [ACC_W-1:0] dot_k;
      assign sv_we = cfg_we && (kind == CFG_SV) && (cfg_pe == PE_AW'(k));
      assign pe_dots[k*ACC_W +: ACC_W] = dot_k;

      svm_pe #(.FEAT_W(FEAT_W), .COEF_W(COEF_W), .ACC_W(ACC_W),
               .FEAT_LEN(FEAT_LEN)) u_pe (
         .clk(clk), .rst_n(rst_n),
         .in_valid(ch_v[k]), .in_start(ch_s[k]), .in_last(ch_l[k]),
         .in_addr(ch_a[k]), .in_data(ch_d[k]),
         .wr_en(sv_we), .wr_addr(cfg_addr), .wr_data(cfg_data),
         .out_valid(ch_v[k+1]), .out_start(ch_s[k+1]), .out_last(ch_l[k+1]),
         .out_addr(ch_a[k+1]), .out_data(ch_d[k+1]),
         .dot(dot_k), .done(pe_done[k]));

      if (k > 0) begin : g_order
         AST_DONE_STAGGER: assert property (@(posedge clk) disable iff (!rst_n)
            pe_done[k] |-> $past(pe_done[k-1]));  // R7
      end
   end

   svm_aggr #(.NUM_SV(NUM_SV), .COEF_W(COEF_W), .ACC_W(ACC_W)) u_aggr (
      .clk(clk), .rst_n(rst_n), .done(pe_done), .dots(pe_dots),
      .wr_alpha(cfg_we && (kind == CFG_ALPHA)),
      .wr_bias(cfg_we && (kind == CFG_BIAS)),
      .wr_idx(cfg_pe), .wr_data(cfg_data),
      .result_valid(result_valid), .result_face(result_face));

   AST_DONE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(pe_done));  // R8
   AST_TAIL_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_v[NUM_SV] && ch_l[NUM_SV]) |-> pe_done[NUM_SV-1]);  // R7
endmodule

// File: tb/svm_poly_chain_tb.sv
module svm_poly_chain_tb;
   localparam int NUM_SV = 8;
   localparam int FEAT_LEN = 64;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0, feat_valid = 1'b0, cfg_we = 1'b0;
   logic [7:0]  feat_data = '0;
   logic [1:0]  cfg_kind = '0;
   logic [2:0]  cfg_pe = '0;
   logic [5:0]  cfg_addr = '0;
   logic [15:0] cfg_data = '0;
   logic result_valid, result_face;

   always #4 clk = ~clk;

   svm_poly_chain u_dut (
      .clk(clk), .rst_n(rst_n), .start(start), .feat_valid(feat_valid),
      .feat_data(feat_data), .cfg_we(cfg_we), .cfg_kind(cfg_kind),
      .cfg_pe(cfg_pe), .cfg_addr(cfg_addr), .cfg_data(cfg_data),
      .result_valid(result_valid), .result_face(result_face));

   typedef struct { bit face; int cyc; } exp_t;
   exp_t exp_q[$];

   int checks = 0, failures = 0, cyc = 0;
   bit finished = 0;
   int sv_m [NUM_SV][FEAT_LEN];
   int alpha_m [NUM_SV];
   int bias_m;
   int feat [FEAT_LEN];

   always @(posedge clk) cyc <= cyc + 1;

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic summary();
      if (!finished) begin
         finished = 1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   endtask

   function automatic bit model_face();
      logic signed [159:0] tot, kk, ak;
      longint d;
      tot = 160'(signed'(bias_m));
      for (int k = 0; k < NUM_SV; k++) begin
         d = 0;
         for (int i = 0; i < FEAT_LEN; i++) d += longint'(feat[i]) * longint'(sv_m[k][i]);
         kk  = 160'(d + 1);
         ak  = 160'(signed'(alpha_m[k]));
         tot = tot + kk * kk * ak;
      end
      return tot > 160'sd0;
   endfunction

   task automatic cfg_wr(input int kind, input int pe, input int addr, input int data);
      @(negedge clk);
      cfg_we = 1'b1; cfg_kind = 2'(kind); cfg_pe = 3'(pe);
      cfg_addr = 6'(addr); cfg_data = 16'(data);
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic load_model();
      for (int k = 0; k < NUM_SV; k++) begin
         for (int i = 0; i < FEAT_LEN; i++) cfg_wr(0, k, i, sv_m[k][i]);
         cfg_wr(1, k, 0, alpha_m[k]);
      end
      cfg_wr(2, 0, 0, bias_m);
   endtask

   task automatic rand_model();
      for (int k = 0; k < NUM_SV; k++) begin
         for (int i = 0; i < FEAT_LEN; i++) sv_m[k][i] = int'($signed(16'($urandom)));
         alpha_m[k] = int'($signed(16'($urandom)));
      end
      bias_m = int'($signed(16'($urandom)));
   endtask

   task automatic rand_feat();
      for (int i = 0; i < FEAT_LEN; i++) feat[i] = int'($urandom % 256);
   endtask

   task automatic idle(input int n);
      for (int j = 0; j < n; j++) begin
         @(negedge clk);
         feat_valid = 1'b0; start = 1'b0;
      end
   endtask

   // driver: streams n elements; pushes the expected decision when the last one goes out
   task automatic drive_vec(input bit gaps, input int n, input bit expect_it);
      exp_t e;
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         if (gaps && ($urandom % 3 == 0)) begin
            feat_valid = 1'b0; start = 1'b0; feat_data = 8'($urandom);
            @(negedge clk);
         end
         start = (i == 0); feat_valid = 1'b1; feat_data = 8'(feat[i]);
         if (expect_it && i == FEAT_LEN - 1) begin
            e.face = model_face();
            e.cyc  = cyc + NUM_SV + 1;
            exp_q.push_back(e);
         end
      end
   endtask

   // monitor: pops expectations as decisions appear
   always @(negedge clk) begin
      if (rst_n && result_valid) begin
         if (exp_q.size() == 0) begin
            chk(1'b0, "R5/R8", "unexpected result_valid", 1, 0);
         end else begin
            exp_t e;
            e = exp_q.pop_front();
            chk(result_face == e.face, "R2/R3", "result_face", result_face, e.face);
            chk(cyc == e.cyc, "R7", "result cycle", cyc, e.cyc);
         end
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      checks++; failures++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 200000);
      summary();
   end

   initial begin
      repeat (3) @(negedge clk);
      chk(result_valid == 1'b0, "R1", "result_valid in reset", result_valid, 0);
      rst_n = 1'b1;
      rand_model();
      load_model();
      chk(result_valid == 1'b0, "R1", "result_valid idle after reset", result_valid, 0);
      chk(exp_q.size() == 0, "R1", "no result before a vector", exp_q.size(), 0);

      // R2 R3 R7: random vectors, continuous stream
      for (int t = 0; t < 4; t++) begin
         rand_feat(); drive_vec(0, FEAT_LEN, 1); idle(NUM_SV + 4);
      end
      // R6: stalls inside the vector
      for (int t = 0; t < 3; t++) begin
         rand_feat(); drive_vec(1, FEAT_LEN, 1); idle(NUM_SV + 4);
      end
      // R8: back-to-back vectors
      for (int t = 0; t < 4; t++) begin
         rand_feat(); drive_vec(0, FEAT_LEN, 1);
      end
      idle(NUM_SV + 4);
      // R5: partial vector discarded by a new start
      rand_feat(); drive_vec(0, 20, 0);
      rand_feat(); drive_vec(0, FEAT_LEN, 1); idle(NUM_SV + 4);
      // R5: stray elements with no open vector are ignored
      for (int j = 0; j < 6; j++) begin
         @(negedge clk); start = 1'b0; feat_valid = 1'b1; feat_data = 8'($urandom);
      end
      idle(NUM_SV + 4);
      chk(exp_q.size() == 0, "R5", "stray elements made no result", exp_q.size(), 0);
      rand_feat(); drive_vec(0, FEAT_LEN, 1); idle(NUM_SV + 4);

      // R4: kind 3 writes change nothing
      for (int k = 0; k < NUM_SV; k++) cfg_wr(3, k, k, 16'h7abc);
      drive_vec(1, FEAT_LEN, 1); idle(NUM_SV + 4);

      // R3: zero boundary, all kernels equal 1 when features are zero
      for (int k = 0; k < NUM_SV; k++) alpha_m[k] = 3;
      for (int i = 0; i < FEAT_LEN; i++) feat[i] = 0;
      bias_m = -3 * NUM_SV;
      load_model();
      drive_vec(0, FEAT_LEN, 1); idle(NUM_SV + 4);   // total 0 -> 0
      bias_m = -3 * NUM_SV + 1; cfg_wr(2, 0, 0, bias_m);
      drive_vec(0, FEAT_LEN, 1); idle(NUM_SV + 4);   // total 1 -> 1

      // R3: dot of -1 gives a zero kernel (offset of one)
      for (int k = 0; k < NUM_SV; k++) begin
         for (int i = 0; i < FEAT_LEN; i++) sv_m[k][i] = (i == 0) ? -1 : 0;
         alpha_m[k] = 1000;
      end
      feat[0] = 1;
      bias_m = 0;
      load_model();
      drive_vec(0, FEAT_LEN, 1); idle(NUM_SV + 4);   // 0 -> 0
      bias_m = 1; cfg_wr(2, 0, 0, bias_m);
      drive_vec(0, FEAT_LEN, 1); idle(NUM_SV + 4);   // 1 -> 1
      feat[0] = 2;                                   // dot -2, kernel 1
      bias_m = -NUM_SV * 1000; cfg_wr(2, 0, 0, bias_m);
      drive_vec(0, FEAT_LEN, 1); idle(NUM_SV + 4);

      idle(20);
      chk(exp_q.size() == 0, "R8", "every vector produced a result", exp_q.size(), 0);
      summary();
   end
endmodule